// File: doc/BRIEF.md
# Double-Buffered Decode Stage Controller

This controller sequences a decode stage that has a pair of input buffers, a single execution core and a pair of output buffers. Every data block passes through three phases in a fixed order: it is loaded into an input buffer, executed by the core into an output buffer, and unloaded from that output buffer to the downstream port. The controller holds no data. It issues start strobes carrying buffer indices to the load, core and unload engines. Each engine answers with a one-cycle done pulse once its phase ends, and how long that takes depends on the block's parameters.

Input and output buffers are tracked in two separate pools. An input buffer returns to its pool as soon as the core finishes with it, and an output buffer returns only when its unload completes. This lets the load of one block, the execution of another and the unload of a third overlap. The total number of accepted blocks that have not yet finished unloading is capped at two. Two short order queues keep the blocks leaving in the order they were accepted.

Top module: `dbuf_stage_ctrl`

## Requirements
- R1: After synchronous reset every busy flag is 0, the in-flight count is 0, and no start strobe is asserted.
- R2: `in_ready` is 1 exactly when an input buffer is free, the load engine is idle and fewer than two blocks are in flight. `ld_start` equals `in_valid & in_ready`, and `ld_buf` is then the lowest-numbered free input buffer.
- R3: `ex_start` is 1 exactly when a loaded block is waiting, the core is idle and an output buffer is free. `ex_in_buf` is then the oldest loaded input buffer, and `ex_out_buf` is the lowest-numbered free output buffer.
- R4: The input buffer held by the core is released by `ex_done`. Its busy flag reads 0 from the following cycle, and it can be allocated again in that cycle but not in the cycle of `ex_done` itself.
- R5: `ul_start` is 1 exactly when `out_ready` is 1, an executed block is waiting and the unload engine is idle. `ul_buf` is then the oldest executed output buffer.
- R6: An output buffer stays busy until `ul_done` for its unload. Its busy flag reads 0 from the cycle after `ul_done`.
- R7: Blocks are unloaded in the order they were accepted at the input port.
- R8: The in-flight count rises by one on each `ld_start` and falls by one on each `ul_done`, and it never exceeds two. While two blocks are in flight, `in_ready` is 0.
- R9: `in_busy[i]` and `out_busy[i]` are 1 from the cycle after the buffer is allocated until the cycle after it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new block is offered at the input port |
| in_ready | output | 1 | The controller can accept a block this cycle |
| out_ready | input | 1 | The downstream port can take a block |
| ld_start | output | 1 | Start strobe to the load engine |
| ld_buf | output | 1 | Input buffer index for the load |
| ld_done | input | 1 | Load engine finished |
| ex_start | output | 1 | Start strobe to the execution core |
| ex_in_buf | output | 1 | Input buffer the core reads |
| ex_out_buf | output | 1 | Output buffer the core writes |
| ex_done | input | 1 | Execution core finished |
| ul_start | output | 1 | Start strobe to the unload engine |
| ul_buf | output | 1 | Output buffer index for the unload |
| ul_done | input | 1 | Unload engine finished |
| in_busy | output | 2 | Per-input-buffer busy flags |
| out_busy | output | 2 | Per-output-buffer busy flags |
| inflight | output | 2 | Blocks accepted but not yet fully unloaded |

## Verification
The hardest situation to reach is the one where the cap, the pools and the order queues all bind at once. In that state both in-flight slots are taken, one block sits executed behind a blocked unload, and a done pulse frees a buffer in the same cycle that a new request appears. Random engine latencies and random `out_ready` produce this situation often. A directed window holds `out_ready` low with `in_valid` high so that the stage fills to the cap, and then releases it so that the queued blocks drain in order. A reference model in the bench, driven only by the port traffic, predicts every strobe, index and flag cycle by cycle.

// File: rtl/stgc_pkg.sv
package stgc_pkg;

    typedef enum logic [1:0] {
        ENG_LOAD   = 2'd0,
        ENG_EXEC   = 2'd1,
        ENG_UNLOAD = 2'd2
    } eng_kind_e;

    // index width for a pool of n entries, at least one bit
    function automatic int unsigned idx_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // counter width able to hold values 0..n
    function automatic int unsigned cnt_w(int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/stgc_buf_pool.sv
module stgc_buf_pool #(
    parameter int unsigned NBUF = 2,
    localparam int unsigned IW = stgc_pkg::idx_w(NBUF)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc,
    input  logic            rel,
    input  logic [IW-1:0]   rel_idx,
    output logic            avail,
    output logic [IW-1:0]   alloc_idx,
    output logic [NBUF-1:0] busy
);
    logic [NBUF-1:0] busy_q;
    logic [NBUF-1:0] set_vec;
    logic [NBUF-1:0] clr_vec;

    always_comb begin
        avail     = 1'b0;
        alloc_idx = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                avail     = 1'b1;
                alloc_idx = IW'(i);
            end
        end
    end

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (alloc) set_vec[alloc_idx] = 1'b1;
        if (rel)   clr_vec[rel_idx]   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) busy_q <= '0;
        else     busy_q <= (busy_q | set_vec) & ~clr_vec;
    end

    assign busy = busy_q;

    // R4
    rel_owned_chk: assert property (@(posedge clk) disable iff (rst)
        rel |-> busy_q[rel_idx]);
    // R9
    alloc_free_chk: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !busy_q[alloc_idx]);
    // R6
    rel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rel |=> !busy_q[$past(rel_idx)]);
endmodule

// File: rtl/stgc_order_q.sv
module stgc_order_q #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned W     = 1,
    localparam int unsigned PW   = stgc_pkg::idx_w(DEPTH),
    localparam int unsigned CW   = stgc_pkg::cnt_w(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] step(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    assign head      = mem[rd_ptr];
    assign not_empty = (count != '0);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && count == CW'(DEPTH)) |-> pop);
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0);
endmodule

// File: rtl/stgc_engine_track.sv
module stgc_engine_track #(
    parameter stgc_pkg::eng_kind_e KIND = stgc_pkg::ENG_LOAD,
    parameter int unsigned AW = 1,
    parameter int unsigned BW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_a,
    input  logic [BW-1:0] start_b,
    input  logic          done,
    output logic          busy,
    output logic [AW-1:0] cur_a,
    output logic [BW-1:0] cur_b
);
    always_ff @(posedge clk) begin
        if (rst)        busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (done)  busy <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)        cur_a <= '0;
        else if (start) cur_a <= start_a;
    end

    generate
        if (KIND == stgc_pkg::ENG_EXEC) begin : g_second_idx
            always_ff @(posedge clk) begin
                if (rst)        cur_b <= '0;
                else if (start) cur_b <= start_b;
            end
        end else begin : g_single_idx
            assign cur_b = '0;
        end
    endgenerate

    // R3
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    // R5
    done_owned_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
endmodule

// File: rtl/dbuf_stage_ctrl.sv
module dbuf_stage_ctrl #(
    parameter int unsigned IN_BUFS      = 2,
    parameter int unsigned OUT_BUFS     = 2,
    parameter int unsigned MAX_INFLIGHT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  logic out_ready,
    output logic ld_start,
    output logic [stgc_pkg::idx_w(IN_BUFS)-1:0] ld_buf,
    input  logic ld_done,
    output logic ex_start,
    output logic [stgc_pkg::idx_w(IN_BUFS)-1:0] ex_in_buf,
    output logic [stgc_pkg::idx_w(OUT_BUFS)-1:0] ex_out_buf,
    input  logic ex_done,
    output logic ul_start,
    output logic [stgc_pkg::idx_w(OUT_BUFS)-1:0] ul_buf,
    input  logic ul_done,
    output logic [IN_BUFS-1:0] in_busy,
    output logic [OUT_BUFS-1:0] out_busy,
    output logic [stgc_pkg::cnt_w(MAX_INFLIGHT)-1:0] inflight
);
    localparam int unsigned IW = stgc_pkg::idx_w(IN_BUFS);
    localparam int unsigned OW = stgc_pkg::idx_w(OUT_BUFS);
    localparam int unsigned FW = stgc_pkg::cnt_w(MAX_INFLIGHT);

    logic          in_avail, out_avail;
    logic [IW-1:0] in_pick;
    logic [OW-1:0] out_pick;
    logic          ld_busy, core_busy, ul_busy;
    logic [IW-1:0] ld_cur, core_in;
    logic [OW-1:0] core_out, ul_cur;
    logic          ld_unused_b;
    logic          ul_unused_b;
    logic          loaded_ne, exec_ne;
    logic [IW-1:0] loaded_head;
    logic [OW-1:0] exec_head;
    logic [FW-1:0] inflight_q;

    // admission and phase launch decisions
    assign in_ready = in_avail && !ld_busy && (inflight_q < FW'(MAX_INFLIGHT));
    assign ld_start = in_valid && in_ready;
    assign ld_buf   = in_pick;

    assign ex_start   = loaded_ne && !core_busy && out_avail;
    assign ex_in_buf  = loaded_head;
    assign ex_out_buf = out_pick;

    assign ul_start = out_ready && exec_ne && !ul_busy;
    assign ul_buf   = exec_head;

    stgc_buf_pool #(.NBUF(IN_BUFS)) in_pool_i (
        .clk(clk), .rst(rst),
        .alloc(ld_start), .rel(ex_done), .rel_idx(core_in),
        .avail(in_avail), .alloc_idx(in_pick), .busy(in_busy)
    );

    stgc_buf_pool #(.NBUF(OUT_BUFS)) out_pool_i (
        .clk(clk), .rst(rst),
        .alloc(ex_start), .rel(ul_done), .rel_idx(ul_cur),
        .avail(out_avail), .alloc_idx(out_pick), .busy(out_busy)
    );

    stgc_engine_track #(.KIND(stgc_pkg::ENG_LOAD), .AW(IW), .BW(1)) ld_eng_i (
        .clk(clk), .rst(rst),
        .start(ld_start), .start_a(in_pick), .start_b(1'b0),
        .done(ld_done), .busy(ld_busy), .cur_a(ld_cur), .cur_b(ld_unused_b)
    );

    stgc_engine_track #(.KIND(stgc_pkg::ENG_EXEC), .AW(IW), .BW(OW)) core_eng_i (
        .clk(clk), .rst(rst),
        .start(ex_start), .start_a(loaded_head), .start_b(out_pick),
        .done(ex_done), .busy(core_busy), .cur_a(core_in), .cur_b(core_out)
    );

    stgc_engine_track #(.KIND(stgc_pkg::ENG_UNLOAD), .AW(OW), .BW(1)) ul_eng_i (
        .clk(clk), .rst(rst),
        .start(ul_start), .start_a(exec_head), .start_b(1'b0),
        .done(ul_done), .busy(ul_busy), .cur_a(ul_cur), .cur_b(ul_unused_b)
    );

    stgc_order_q #(.DEPTH(MAX_INFLIGHT), .W(IW)) loaded_q_i (
        .clk(clk), .rst(rst),
        .push(ld_done), .push_data(ld_cur), .pop(ex_start),
        .head(loaded_head), .not_empty(loaded_ne)
    );

    stgc_order_q #(.DEPTH(MAX_INFLIGHT), .W(OW)) exec_q_i (
        .clk(clk), .rst(rst),
        .push(ex_done), .push_data(core_out), .pop(ul_start),
        .head(exec_head), .not_empty(exec_ne)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= '0;
        end else begin
            case ({ld_start, ul_done})
                2'b10:   inflight_q <= inflight_q + 1'b1;
                2'b01:   inflight_q <= inflight_q - 1'b1;
                default: inflight_q <= inflight_q;
            endcase
        end
    end

    assign inflight = inflight_q;

    // R8
    inflight_cap_chk: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= FW'(MAX_INFLIGHT));
    // R3
    ex_src_loaded_chk: assert property (@(posedge clk) disable iff (rst)
        ex_start |-> in_busy[ex_in_buf]);
    // R5
    ul_src_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ul_start |-> out_busy[ul_buf]);
    // R8
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (inflight_q == FW'(MAX_INFLIGHT)) |-> !in_ready);
endmodule

// File: tb/dbuf_stage_ctrl_tb.sv
module dbuf_stage_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready, out_ready;
    logic ld_start, ld_done, ex_start, ex_done, ul_start, ul_done;
    logic ld_buf, ex_in_buf, ex_out_buf, ul_buf;
    logic [1:0] in_busy, out_busy, inflight;

    always #2 clk = ~clk;

    dbuf_stage_ctrl dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .out_ready(out_ready), .ld_start(ld_start), .ld_buf(ld_buf),
        .ld_done(ld_done), .ex_start(ex_start), .ex_in_buf(ex_in_buf),
        .ex_out_buf(ex_out_buf), .ex_done(ex_done), .ul_start(ul_start),
        .ul_buf(ul_buf), .ul_done(ul_done), .in_busy(in_busy),
        .out_busy(out_busy), .inflight(inflight)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    int m_in_busy[2], m_out_busy[2];
    int m_ld_busy, m_ld_buf, m_ld_cnt;
    int m_ex_busy, m_ex_in, m_ex_out, m_ex_cnt;
    int m_ul_busy, m_ul_buf, m_ul_cnt;
    int m_inflight;
    int lq[$];
    int eq[$];
    int id_in[2], id_out[2];
    int next_id, next_out_id;
    bit pending;

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lowest_free(int b0, int b1);
        if (b0 == 0) return 0;
        if (b1 == 0) return 1;
        return -1;
    endfunction

    function automatic int rand_lat(int maxl);
        return 1 + int'($urandom % maxl);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // one cycle: drive at negedge, check, then advance the model
    task automatic cycle(int p_valid, int p_ready, int maxl);
        int fin, fout;
        bit e_rdy, e_ld, e_ex, e_ul;
        @(negedge clk);
        ld_done = (m_ld_busy != 0) && (m_ld_cnt == 0);
        ex_done = (m_ex_busy != 0) && (m_ex_cnt == 0);
        ul_done = (m_ul_busy != 0) && (m_ul_cnt == 0);
        if (!pending && int'($urandom % 100) < p_valid) pending = 1;
        in_valid  = pending;
        out_ready = int'($urandom % 100) < p_ready;
        #1;
        fin  = lowest_free(m_in_busy[0], m_in_busy[1]);
        fout = lowest_free(m_out_busy[0], m_out_busy[1]);
        e_rdy = (fin >= 0) && (m_ld_busy == 0) && (m_inflight < 2);
        e_ld  = in_valid && e_rdy;
        e_ex  = (lq.size() > 0) && (m_ex_busy == 0) && (fout >= 0);
        e_ul  = out_ready && (eq.size() > 0) && (m_ul_busy == 0);
        // R9 busy flags, R8 count
        chk("R9 in_busy", int'(in_busy), m_in_busy[1] * 2 + m_in_busy[0]);
        chk("R9 out_busy", int'(out_busy), m_out_busy[1] * 2 + m_out_busy[0]);
        chk("R8 inflight", int'(inflight), m_inflight);
        // R2 admission
        chk("R2 in_ready", int'(in_ready), int'(e_rdy));
        chk("R2 ld_start", int'(ld_start), int'(e_ld));
        if (e_ld) chk("R2 ld_buf", int'(ld_buf), fin);
        // R3 execution launch
        chk("R3 ex_start", int'(ex_start), int'(e_ex));
        if (e_ex) begin
            chk("R3 ex_in_buf", int'(ex_in_buf), lq[0]);
            chk("R3 ex_out_buf", int'(ex_out_buf), fout);
        end
        // R5 unload launch
        chk("R5 ul_start", int'(ul_start), int'(e_ul));
        if (e_ul) chk("R5 ul_buf", int'(ul_buf), eq[0]);
        // R7 order tracking through the indices the design reports
        if (ld_start) id_in[ld_buf] = next_id++;
        if (ex_start) id_out[ex_out_buf] = id_in[ex_in_buf];
        if (ul_start) begin
            chk("R7 unload order", id_out[ul_buf], next_out_id);
            next_out_id++;
        end
        // advance the model (what happens at the coming edge)
        if (m_ld_busy != 0 && m_ld_cnt > 0) m_ld_cnt--;
        if (m_ex_busy != 0 && m_ex_cnt > 0) m_ex_cnt--;
        if (m_ul_busy != 0 && m_ul_cnt > 0) m_ul_cnt--;
        if (ld_done) begin lq.push_back(m_ld_buf); m_ld_busy = 0; end
        if (ex_done) begin m_in_busy[m_ex_in] = 0; eq.push_back(m_ex_out); m_ex_busy = 0; end
        if (ul_done) begin m_out_busy[m_ul_buf] = 0; m_inflight--; m_ul_busy = 0; end
        if (e_ld) begin
            m_in_busy[fin] = 1; m_ld_busy = 1; m_ld_buf = fin;
            m_ld_cnt = rand_lat(maxl) - 1; m_inflight++; pending = 0;
        end
        if (e_ex) begin
            m_ex_in = lq.pop_front(); m_out_busy[fout] = 1; m_ex_out = fout;
            m_ex_busy = 1; m_ex_cnt = rand_lat(maxl) - 1;
        end
        if (e_ul) begin
            m_ul_buf = eq.pop_front(); m_ul_busy = 1; m_ul_cnt = rand_lat(maxl) - 1;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        rst = 1; in_valid = 0; out_ready = 0;
        ld_done = 0; ex_done = 0; ul_done = 0;
        for (int i = 0; i < 2; i++) begin
            m_in_busy[i] = 0; m_out_busy[i] = 0; id_in[i] = 0; id_out[i] = 0;
        end
        m_ld_busy = 0; m_ex_busy = 0; m_ul_busy = 0;
        m_ld_cnt = 0; m_ex_cnt = 0; m_ul_cnt = 0;
        m_ld_buf = 0; m_ex_in = 0; m_ex_out = 0; m_ul_buf = 0;
        m_inflight = 0; next_id = 0; next_out_id = 0; pending = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 in_busy", int'(in_busy), 0);
        chk("R1 out_busy", int'(out_busy), 0);
        chk("R1 inflight", int'(inflight), 0);
        chk("R1 ex_start", int'(ex_start), 0);
        chk("R1 ul_start", int'(ul_start), 0);
        // directed: single-cycle engines, always ready (R4 same-cycle reuse pressure)
        for (int c = 0; c < 200; c++) cycle(100, 100, 1);
        // random mix
        for (int c = 0; c < 3000; c++) cycle(70, 60, 6);
        // directed: downstream blocked, stage fills to the cap
        for (int c = 0; c < 120; c++) cycle(100, 0, 4);
        @(negedge clk);
        #1;
        chk("R8 full inflight", int'(inflight), 2);
        chk("R8 full in_ready", int'(in_ready), 0);
        // drain with long latencies, no new blocks after the pending one
        for (int c = 0; c < 400; c++) cycle(0, 100, 9);
        chk("R7 all unloaded", next_out_id, next_id);
        chk("R6 drained out_busy", int'(out_busy), 0);
        chk("R4 drained in_busy", int'(in_busy), 0);
        chk("R7 progress", int'(next_out_id > 100), 1);
        finish_run();
    end
endmodule